// File: doc/BRIEF.md
# Dual-Bucket Token Rate Shaper

This block limits the traffic leaving one scheduling node with two token buckets: a committed bucket and a peak bucket. Each bucket is set up by writing one 32-bit parameter word through a small write port, with a one-bit select that picks the bucket. The word holds a rate mantissa, an up-shift and a down-shift exponent, and a burst mantissa and exponent. A bucket gains `mantissa << up_shift` bytes of credit once every `tick_base << down_shift` clock cycles. Its level never rises above the burst cap `burst_mantissa << burst_exponent`. The base tick is fixed when the node is built, by its level in the scheduling tree: 1536 cycles for a priority node or a queue-set node, 192 for a priority-group node and 48 for a port node.

A packet source shows a byte length together with a valid strobe. The node answers at once with an eligibility flag and a grant. A granted packet takes its length from every enabled bucket, and a level may go below zero. The node stays ineligible until refills bring each enabled bucket back to zero or above. Packet storage, queue selection and the conversion from a rate in Mbps to parameter words are outside this block.

Each bucket runs a two-state machine. B_OFF means disabled: the bucket does not limit, and it is the reset state. B_RUN means counting and limiting. A write moves the bucket from B_OFF to B_RUN, unless it is a committed-bucket word whose three rate fields are all zero. Such a zero-rate committed write moves the bucket from B_RUN back to B_OFF, or keeps it in B_OFF. Any write to the peak bucket leaves it in B_RUN. Every write reloads the bucket's level to its burst cap and restarts its tick counter.

Top module: `rate_shaper_node`

## Requirements
- R1: After reset both buckets are in B_OFF, `eligible` is 1, and any request is granted without limit.
- R2: A committed-bucket write (`cfg_sel`=0) whose rate fields are all zero (bits [15:0] = 0) leaves the committed bucket disabled. Granted packets then have no effect on eligibility.
- R3: The parameter word is decoded as follows: rate mantissa in bits [7:0], up-shift in [11:8], down-shift in [15:12], burst mantissa in [20:16] and burst exponent in [25:21]. Bits [31:26] are ignored.
- R4: A write sets that bucket's level to its burst cap at the write edge and restarts its tick counter. Rewriting a bucket whose level is negative makes it non-limiting again at once.
- R5: While a bucket is in B_RUN, it adds `mantissa << up_shift` bytes at every edge that is a whole multiple of `tick_base << down_shift` edges after its write edge.
- R6: The base tick is 1536 cycles for node level 0 (priority) and level 3 (queue set), 192 for level 1 (priority group) and 48 for level 2 (port).
- R7: A refill never lifts a level above the burst cap.
- R8: `eligible` is 1 exactly when every enabled bucket has a level of zero or more. A level of exactly zero counts as eligible.
- R9: `grant` equals `req_valid` AND `eligible`. A grant takes `req_len` from every enabled bucket at that edge. A request that is not granted takes nothing.
- R10: The peak bucket (`cfg_sel`=1) is configured independently of the committed bucket and is enabled by any write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Parameter word write strobe |
| cfg_sel | input | 1 | Bucket select: 0 committed, 1 peak |
| cfg_word | input | 32 | Packed parameter word |
| req_valid | input | 1 | Packet request present |
| req_len | input | LEN_W | Packet length in bytes |
| eligible | output | 1 | All enabled buckets are at zero or above |
| grant | output | 1 | Request accepted this cycle |

## Verification
A wrong bucket level or a wrong tick count shows at the ports only as `eligible` changing in the wrong cycle. The bench therefore pushes a bucket just below zero and checks the flag in the cycle before and the cycle after the expected refill edge, so an off-by-one period fails within one tick. A cap that does not saturate becomes visible at the next packet that exceeds the cap by one byte. A request that was debited without a grant becomes visible when the next refill fails to restore eligibility.

// File: rtl/shaper_pkg.sv
package shaper_pkg;

    localparam int NBKT     = 2;
    localparam int DEF_BS_B = 1;
    localparam int DEF_BS_S = 4;

    typedef struct packed {
        logic [4:0] bs_s;
        logic [4:0] bs_b;
        logic [3:0] ir_s;
        logic [3:0] ir_u;
        logic [7:0] ir_b;
    } shp_param_t;

    localparam int PAR_W = $bits(shp_param_t);

    typedef enum logic {
        B_OFF = 1'b0,
        B_RUN = 1'b1
    } bkt_state_t;

    function automatic int shp_tick_base(input int level);
        case (level)
            1:       return 192;
            2:       return 48;
            default: return 1536;
        endcase
    endfunction

endpackage

// File: rtl/shaper_ticker.sv
module shaper_ticker #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [CNT_W-1:0] period,
    output logic             tick
);
    logic [CNT_W-1:0] cnt;
    logic             at_end;

    assign at_end = (cnt == period - CNT_W'(1));
    assign tick   = run && !restart && at_end;

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= at_end ? '0 : cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/shaper_bucket.sv
module shaper_bucket
    import shaper_pkg::*;
#(
    parameter int LEVEL     = 2,
    parameter int LVL_W     = 40,
    parameter int LEN_W     = 16,
    parameter int CNT_W     = 32,
    parameter bit IS_COMMIT = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr,
    input  logic [PAR_W-1:0]        word,
    input  logic                    debit,
    input  logic [LEN_W-1:0]        len,
    output logic                    ok,
    output logic                    en,
    output logic signed [LVL_W-1:0] level,
    output logic signed [LVL_W-1:0] cap
);
    localparam int TICK_BASE = shp_tick_base(LEVEL);

    bkt_state_t st, st_nx;
    shp_param_t par, w;
    logic signed [LVL_W-1:0] inc, w_cap, len_s, sum, sat, lvl_nx;
    logic [CNT_W-1:0] period;
    logic tick, w_zero, running;

    assign w       = shp_param_t'(word);
    assign w_zero  = IS_COMMIT && (w.ir_b == '0) && (w.ir_u == '0) && (w.ir_s == '0);
    assign w_cap   = LVL_W'(w.bs_b) << w.bs_s;
    assign cap     = LVL_W'(par.bs_b) << par.bs_s;
    assign inc     = LVL_W'(par.ir_b) << par.ir_u;
    assign period  = CNT_W'(TICK_BASE) << par.ir_s;
    assign len_s   = LVL_W'(len);
    assign running = (st == B_RUN);

    shaper_ticker #(.CNT_W(CNT_W)) u_ticker (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wr),
        .run     (running),
        .period  (period),
        .tick    (tick)
    );

    always_comb begin
        st_nx = st;
        unique case (st)
            B_OFF:   if (wr && !w_zero) st_nx = B_RUN;
            B_RUN:   if (wr && w_zero)  st_nx = B_OFF;
            default: st_nx = B_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= B_OFF;
        else        st <= st_nx;
    end

    always_comb begin
        sum    = tick ? level + inc : level;
        sat    = (sum > cap) ? cap : sum;
        lvl_nx = debit ? sat - len_s : sat;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par   <= '{bs_s: 5'(DEF_BS_S), bs_b: 5'(DEF_BS_B), ir_s: 4'd0, ir_u: 4'd0, ir_b: 8'd0};
            level <= LVL_W'(DEF_BS_B) << DEF_BS_S;
        end else if (wr) begin
            par   <= w;
            level <= w_cap;
        end else if (running) begin
            level <= lvl_nx;
        end
    end

    always_comb begin
        en = running;
        ok = !running || !level[LVL_W-1];
    end
endmodule

// File: rtl/rate_shaper_node.sv
module rate_shaper_node
    import shaper_pkg::*;
#(
    parameter int LEVEL = 2,
    parameter int LVL_W = 40,
    parameter int LEN_W = 16,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [31:0]      cfg_word,
    input  logic             req_valid,
    input  logic [LEN_W-1:0] req_len,
    output logic             eligible,
    output logic             grant
);
    logic [NBKT-1:0]         bkt_ok;
    logic [NBKT-1:0]         bkt_en;
    logic signed [LVL_W-1:0] bkt_lvl [NBKT];
    logic signed [LVL_W-1:0] bkt_cap [NBKT];
    logic                    unused_hi;

    assign unused_hi = ^cfg_word[31:PAR_W];

    for (genvar b = 0; b < NBKT; b++) begin : g_bkt
        shaper_bucket #(
            .LEVEL     (LEVEL),
            .LVL_W     (LVL_W),
            .LEN_W     (LEN_W),
            .CNT_W     (CNT_W),
            .IS_COMMIT (b == 0)
        ) u_bucket (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (cfg_we && (cfg_sel == 1'(b))),
            .word  (cfg_word[PAR_W-1:0]),
            .debit (grant),
            .len   (req_len),
            .ok    (bkt_ok[b]),
            .en    (bkt_en[b]),
            .level (bkt_lvl[b]),
            .cap   (bkt_cap[b])
        );
    end

    assign eligible = &bkt_ok;
    assign grant    = req_valid && eligible;
endmodule

// File: rtl/rate_shaper_node_chk.sv
module rate_shaper_node_chk #(
    parameter int LVL_W = 40
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cfg_we,
    input logic                    cfg_sel,
    input logic [31:0]             cfg_word,
    input logic                    grant,
    input logic                    en_c,
    input logic                    en_p,
    input logic signed [LVL_W-1:0] lvl_c,
    input logic signed [LVL_W-1:0] lvl_p,
    input logic signed [LVL_W-1:0] cap_c,
    input logic signed [LVL_W-1:0] cap_p
);
    logic signed [LVL_W-1:0] w_cap;
    logic                    chk_unused;

    assign w_cap      = LVL_W'(cfg_word[20:16]) << cfg_word[25:21];
    assign chk_unused = ^{cfg_word[31:26], cfg_word[15:0]};

    // R4: a committed write loads the burst cap taken from the word
    a_r4_write_loads_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_sel) |=> (lvl_c == $past(w_cap)));

    // R7: an enabled level never exceeds its cap
    a_r7_commit_capped: assert property (@(posedge clk) disable iff (!rst_n)
        en_c |-> (lvl_c <= cap_c));
    a_r7_peak_capped: assert property (@(posedge clk) disable iff (!rst_n)
        en_p |-> (lvl_p <= cap_p));

    // R9: without a grant or a write the committed level cannot fall
    a_r9_no_drop_without_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (en_c && !cfg_we && !grant) |=> (lvl_c >= $past(lvl_c)));

    // R2: a zero-rate committed word disables the committed bucket
    a_r2_zero_rate_off: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_sel && (cfg_word[15:0] == 16'd0)) |=> !en_c);

    // R10: any peak write enables the peak bucket
    a_r10_peak_on: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel) |=> en_p);
endmodule

bind rate_shaper_node rate_shaper_node_chk #(.LVL_W(LVL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_word (cfg_word),
    .grant    (grant),
    .en_c     (bkt_en[0]),
    .en_p     (bkt_en[1]),
    .lvl_c    (bkt_lvl[0]),
    .lvl_p    (bkt_lvl[1]),
    .cap_c    (bkt_cap[0]),
    .cap_p    (bkt_cap[1])
);

// File: tb/rate_shaper_node_bench.sv
module rate_shaper_node_bench;
    localparam int LEN_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic             cfg_sel = 1'b0;
    logic [31:0]      cfg_word = '0;
    logic             req_valid = 1'b0;
    logic [LEN_W-1:0] req_len = '0;
    logic             eligible, grant, elig_pg, grant_pg;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    rate_shaper_node #(.LEVEL(2), .LEN_W(LEN_W)) u_rate_shaper_node (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_word(cfg_word), .req_valid(req_valid), .req_len(req_len),
        .eligible(eligible), .grant(grant)
    );

    rate_shaper_node #(.LEVEL(1), .LEN_W(LEN_W)) u_rate_shaper_node_pg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_word(cfg_word), .req_valid(req_valid), .req_len(req_len),
        .eligible(elig_pg), .grant(grant_pg)
    );

    function automatic logic [31:0] mk(input int bss, input int bsb, input int irs,
                                        input int iru, input int irb);
        return {6'b0, 5'(bss), 5'(bsb), 4'(irs), 4'(iru), 8'(irb)};
    endfunction

    task automatic chk(input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0b exp=%0b", what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    // call at a negedge; returns one negedge after the write edge
    task automatic cfg(input logic sel, input logic [31:0] word);
        cfg_we = 1'b1; cfg_sel = sel; cfg_word = word;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pkt(input int len, output logic g);
        req_valid = 1'b1; req_len = LEN_W'(len);
        #1 g = grant;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic g;
        chk("R1 eligible after reset", eligible, 1'b1);
        pkt(1000, g);
        chk("R1 big packet granted", g, 1'b1);
        pkt(60000, g);
        chk("R9 grant while unlimited", g, 1'b1);
        chk("R1 still eligible", eligible, 1'b1);
    endtask

    task automatic t_zero_commit();
        logic g;
        cfg(1'b0, mk(4, 1, 0, 0, 0) | 32'hFC00_0000);
        pkt(500, g);
        chk("R2 zero-rate committed grants", g, 1'b1);
        chk("R2 zero-rate committed not limiting", eligible, 1'b1);
    endtask

    task automatic t_period();
        logic g;
        cfg(1'b0, mk(4, 1, 0, 0, 4));      // cap 16, +4 per tick
        pkt(17, g);                        // level -1
        chk("R8 negative level ineligible", eligible, 1'b0);
        step(46);
        chk("R5 no refill before 48 edges", eligible, 1'b0);
        step(1);
        chk("R5 refill at edge 48", eligible, 1'b1);
        chk("R6 group level not yet refilled", elig_pg, 1'b0);
        step(143);
        chk("R6 group level before 192", elig_pg, 1'b0);
        step(1);
        chk("R6 group level refill at 192", elig_pg, 1'b1);
    endtask

    task automatic t_cap();
        logic g;
        cfg(1'b0, mk(4, 1, 0, 0, 200));    // cap 16, +200 per tick
        step(99);
        pkt(16, g);                        // level 0
        chk("R8 zero level eligible", eligible, 1'b1);
        pkt(1, g);                         // level -1
        chk("R8 level -1 ineligible", eligible, 1'b0);
        step(42);
        chk("R5 before third tick", eligible, 1'b0);
        step(1);
        chk("R5 refill at edge 144", eligible, 1'b1);
        pkt(17, g);
        chk("R7 refill saturated at cap", eligible, 1'b0);
    endtask

    task automatic t_shift();
        logic g;
        cfg(1'b0, mk(4, 1, 1, 3, 1));      // +8 every 96 cycles
        pkt(24, g);                        // level -8
        chk("R3 debit below zero", eligible, 1'b0);
        step(47);
        chk("R3 down-shift skips edge 48", eligible, 1'b0);
        step(47);
        chk("R3 before edge 96", eligible, 1'b0);
        step(1);
        chk("R3 up-shift adds 8 at edge 96", eligible, 1'b1);
    endtask

    task automatic t_peak();
        logic g;
        logic any_g = 1'b0;
        cfg(1'b0, 32'h0);                  // committed off
        cfg(1'b1, mk(2, 2, 0, 0, 1));      // peak cap 8, +1 per tick
        pkt(9, g);                         // peak -1
        chk("R10 peak alone limits", eligible, 1'b0);
        req_valid = 1'b1; req_len = LEN_W'(100);
        for (int i = 0; i < 38; i++) begin
            #1 any_g = any_g | grant;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk("R9 no grant while ineligible", any_g, 1'b0);
        step(8);
        chk("R9 before refill", eligible, 1'b0);
        step(1);
        chk("R9 undebited refill restores", eligible, 1'b1);
    endtask

    task automatic t_both();
        logic g;
        cfg(1'b0, mk(4, 1, 0, 0, 1));      // committed cap 16
        cfg(1'b1, mk(2, 2, 0, 0, 1));      // peak cap 8
        pkt(12, g);
        chk("R9 grant when eligible", g, 1'b1);
        chk("R8 both enabled, peak negative", eligible, 1'b0);
        cfg(1'b1, mk(2, 2, 0, 0, 1));
        chk("R4 rewrite reloads cap", eligible, 1'b1);
        pkt(5, g);
        chk("R8 committed negative blocks", eligible, 1'b0);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_zero_commit();
        t_period();
        t_cap();
        t_shift();
        t_peak();
        t_both();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog act=running exp=finished");
            summary();
            $finish;
        end
    end
endmodule